// File: doc/BRIEF.md
# Core cycle and instruction counter

This unit sits inside a processor core and measures how long a piece of code runs and how much work it does. It counts elapsed clock cycles, retired instructions, or both at once in two separate counters. Cycle counting advances on every clock, so it includes cycles where the core waits on memory transfers. Instruction counting advances only on the per-cycle retire strobe.

Software drives the unit through a small register interface. A configuration write selects a counting mode and carries a clear flag. With the flag set, the count restarts from zero. With the flag clear, counting continues from the current value. Either way, the response carries the values the counters held before the write, so a checkpoint can be taken without a separate read. A read request returns the primary counter, and optionally the secondary counter as well. Every response comes back one cycle after its request.

Each counter is 36 bits wide by default and is visible only in steps of 16 events. A hidden 4-bit prescaler collects raw events, and the visible upper part moves on its carry, so the low four bits always read as zero.

Top module: `pmc_core_counter`

## Requirements
- R1: After reset, both counters read zero, counting is disabled, and `rsp_valid_o` is low until a request arrives.
- R2: Mode codes on `cfg_mode_i` are 0 = cycles, 1 = instructions, 2 = reuse previous selection, 3 = both, 4 = disable. A new mode takes effect from the cycle after the write. An event in the cycle of a keeping write is counted under the old mode.
- R3: In cycle mode, counter A counts every clock. In instruction mode, counter A counts cycles with `retire_i` high. In both single modes, counter B holds its value.
- R4: In dual mode (code 3), counter A counts cycles and counter B counts retired instructions, each independently.
- R5: The visible low 4 bits of each counter are always zero. A visible value advances by exactly 16 once 16 raw events have accumulated since the last clear.
- R6: Each counter wraps modulo 2^CNT_W (2^36 by default) on overflow.
- R7: Code 2, and the unused codes 5 to 7, restore the last explicitly selected mode (0, 1, 3 or 4). If no explicit selection has been made since reset, they select cycle counting.
- R8: In disable mode (code 4), both counters hold their values regardless of clock or retire activity, and reads still return those values.
- R9: A configuration write with `cfg_clear_i` high clears both counters and their prescalers to zero. Any event in that same cycle is discarded.
- R10: One cycle after any configuration write, `rsp_valid_o` is high. `rsp_a_o` and `rsp_b_o` then carry counters A and B as they stood before the write.
- R11: One cycle after a read request, `rsp_valid_o` is high and `rsp_a_o` carries counter A. `rsp_b_o` carries counter B when `rd_both_i` is high, and zero otherwise.
- R12: When a configuration write and a read request arrive in the same cycle, only the configuration is served. The read is dropped and a single configuration response is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retire_i | input | 1 | One instruction retired in this cycle |
| cfg_valid_i | input | 1 | Single-cycle configuration write strobe |
| cfg_mode_i | input | 3 | Mode code for the configuration write |
| cfg_clear_i | input | 1 | Clear both counters with this write |
| rd_valid_i | input | 1 | Single-cycle read request strobe |
| rd_both_i | input | 1 | Return counter B along with counter A |
| rsp_valid_o | output | 1 | Response present, one cycle after a request |
| rsp_a_o | output | CNT_W | Counter A value in the response |
| rsp_b_o | output | CNT_W | Counter B value, or zero for a single read |

## Verification
The assertions assume that request strobes are single-cycle pulses and that every request is answered on the next cycle. No back-pressure or queueing is expected. They also assume the retire strobe is at most one event per cycle, so a counter moves by at most one prescaler step per clock. The stimulus keeps within these assumptions. It drives every input on the falling edge, gives each request exactly one cycle, and mixes random mode codes, including the unused ones, with sparse configuration writes and frequent reads.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    // Encoded mode selection carried by a configuration write.
    typedef enum logic [2:0] {
        MODE_CYC  = 3'd0,
        MODE_INS  = 3'd1,
        MODE_SAME = 3'd2,
        MODE_BOTH = 3'd3,
        MODE_OFF  = 3'd4
    } pmc_mode_e;

    localparam int unsigned NUM_CTR = 2;

    // True when a raw code names a concrete mode rather than a reuse request.
    function automatic logic is_explicit(input logic [2:0] code);
        return (code == MODE_CYC) || (code == MODE_INS) ||
               (code == MODE_BOTH) || (code == MODE_OFF);
    endfunction

endpackage

// File: rtl/pmc_mode_ctrl.sv
module pmc_mode_ctrl
    import pmc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_valid_i,
    input  logic [2:0] cfg_mode_i,
    output pmc_mode_e  mode_o
);

    typedef struct packed {
        pmc_mode_e active;
        pmc_mode_e last;
    } mode_state_t;

    mode_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_valid_i) begin
            if (is_explicit(cfg_mode_i)) begin
                st_d.active = pmc_mode_e'(cfg_mode_i);
                st_d.last   = pmc_mode_e'(cfg_mode_i);
            end else begin
                // reuse request: fall back to the remembered selection
                st_d.active = st_q.last;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.active <= MODE_OFF;
            st_q.last   <= MODE_CYC;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o = st_q.active;

endmodule

// File: rtl/pmc_event_route.sv
module pmc_event_route
    import pmc_pkg::*;
(
    input  pmc_mode_e           mode_i,
    input  logic                retire_i,
    output logic [NUM_CTR-1:0]  inc_o
);

    // index 0 = counter A, index 1 = counter B
    always_comb begin
        inc_o = '0;
        unique case (mode_i)
            MODE_CYC:  inc_o[0] = 1'b1;
            MODE_INS:  inc_o[0] = retire_i;
            MODE_BOTH: begin
                inc_o[0] = 1'b1;
                inc_o[1] = retire_i;
            end
            default:   inc_o = '0;
        endcase
    end

endmodule

// File: rtl/pmc_event_ctr.sv
module pmc_event_ctr #(
    parameter int unsigned CNT_W  = 36,
    parameter int unsigned FRAC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] value_o
);

    localparam int unsigned WHOLE_W = CNT_W - FRAC_W;

    typedef struct packed {
        logic [FRAC_W-1:0]  frac;
        logic [WHOLE_W-1:0] whole;
    } ctr_state_t;

    ctr_state_t ctr_d, ctr_q;
    logic [FRAC_W:0] frac_sum;

    always_comb begin
        ctr_d    = ctr_q;
        frac_sum = {1'b0, ctr_q.frac} + {{FRAC_W{1'b0}}, 1'b1};
        if (clr_i) begin
            ctr_d = '0;
        end else if (inc_i) begin
            ctr_d.frac  = frac_sum[FRAC_W-1:0];
            ctr_d.whole = ctr_q.whole + {{(WHOLE_W-1){1'b0}}, frac_sum[FRAC_W]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctr_q <= '0;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign value_o = {ctr_q.whole, {FRAC_W{1'b0}}};

endmodule

// File: rtl/pmc_core_counter.sv
module pmc_core_counter
    import pmc_pkg::*;
#(
    parameter int unsigned CNT_W  = 36,
    parameter int unsigned FRAC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             retire_i,
    input  logic             cfg_valid_i,
    input  logic [2:0]       cfg_mode_i,
    input  logic             cfg_clear_i,
    input  logic             rd_valid_i,
    input  logic             rd_both_i,
    output logic             rsp_valid_o,
    output logic [CNT_W-1:0] rsp_a_o,
    output logic [CNT_W-1:0] rsp_b_o
);

    typedef struct packed {
        logic             valid;
        logic [CNT_W-1:0] a;
        logic [CNT_W-1:0] b;
    } rsp_t;

    pmc_mode_e          mode_q;
    logic [NUM_CTR-1:0] inc;
    logic [CNT_W-1:0]   cnt_val [NUM_CTR];
    logic [CNT_W-1:0]   cnt_a_val, cnt_b_val;
    logic               clr_all;
    rsp_t               rsp_d, rsp_q;

    assign clr_all = cfg_valid_i & cfg_clear_i;

    pmc_mode_ctrl u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_valid_i (cfg_valid_i),
        .cfg_mode_i  (cfg_mode_i),
        .mode_o      (mode_q)
    );

    pmc_event_route u_route (
        .mode_i   (mode_q),
        .retire_i (retire_i),
        .inc_o    (inc)
    );

    for (genvar gi = 0; gi < NUM_CTR; gi++) begin : g_ctr
        pmc_event_ctr #(
            .CNT_W  (CNT_W),
            .FRAC_W (FRAC_W)
        ) u_ctr (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr_i   (clr_all),
            .inc_i   (inc[gi]),
            .value_o (cnt_val[gi])
        );
    end

    assign cnt_a_val = cnt_val[0];
    assign cnt_b_val = cnt_val[1];

    // Configuration outranks a read issued in the same cycle.
    always_comb begin
        rsp_d = '0;
        if (cfg_valid_i) begin
            rsp_d.valid = 1'b1;
            rsp_d.a     = cnt_a_val;
            rsp_d.b     = cnt_b_val;
        end else if (rd_valid_i) begin
            rsp_d.valid = 1'b1;
            rsp_d.a     = cnt_a_val;
            rsp_d.b     = rd_both_i ? cnt_b_val : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid_o = rsp_q.valid;
    assign rsp_a_o     = rsp_q.a;
    assign rsp_b_o     = rsp_q.b;

endmodule

// File: rtl/pmc_core_counter_chk.sv
module pmc_core_counter_chk
    import pmc_pkg::*;
#(
    parameter int unsigned CNT_W  = 36,
    parameter int unsigned FRAC_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_valid_i,
    input logic             cfg_clear_i,
    input logic             rd_valid_i,
    input logic             rd_both_i,
    input logic             rsp_valid_o,
    input logic [CNT_W-1:0] rsp_a_o,
    input logic [CNT_W-1:0] rsp_b_o,
    input logic [CNT_W-1:0] cnt_a,
    input logic [CNT_W-1:0] cnt_b,
    input pmc_mode_e        mode_q
);

    localparam logic [CNT_W-1:0] STEP = CNT_W'(1) << FRAC_W;

    // R10 R11: every request is answered exactly one cycle later
    p_rsp_next_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid_i || rd_valid_i) |=> rsp_valid_o);
    p_rsp_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_valid_i || rd_valid_i) |=> !rsp_valid_o);

    // R5: visible low bits never set
    p_low_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> (rsp_a_o[FRAC_W-1:0] == '0) && (rsp_b_o[FRAC_W-1:0] == '0));

    // R5: visible value moves by zero or one step per cycle
    p_step_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_valid_i && cfg_clear_i) |=>
            (cnt_a == $past(cnt_a)) || (cnt_a == $past(cnt_a) + STEP));

    // R9: clearing write zeroes both counters
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid_i && cfg_clear_i) |=> (cnt_a == '0) && (cnt_b == '0));

    // R8: disable mode freezes both counters
    p_off_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_OFF) && !cfg_valid_i |=> $stable(cnt_a) && $stable(cnt_b));

    // R3: counter B only moves in dual mode
    p_b_dual_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != MODE_BOTH) && !cfg_valid_i |=> $stable(cnt_b));

    // R11: a single read returns zero in the B field
    p_single_b_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_i && !rd_both_i && !cfg_valid_i) |=> (rsp_b_o == '0));

endmodule

bind pmc_core_counter pmc_core_counter_chk #(
    .CNT_W  (CNT_W),
    .FRAC_W (FRAC_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_valid_i (cfg_valid_i),
    .cfg_clear_i (cfg_clear_i),
    .rd_valid_i  (rd_valid_i),
    .rd_both_i   (rd_both_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_a_o     (rsp_a_o),
    .rsp_b_o     (rsp_b_o),
    .cnt_a       (cnt_a_val),
    .cnt_b       (cnt_b_val),
    .mode_q      (mode_q)
);

// File: tb/pmc_core_counter_test.sv
module pmc_core_counter_test;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 36;
    localparam int WS         = 8;

    logic clk = 1'b0;
    logic rst_n;
    logic retire, cfg_valid, cfg_clear, rd_valid, rd_both;
    logic [2:0] cfg_mode;
    logic rsp_valid;
    logic [W-1:0] rsp_a, rsp_b;

    logic w_cfg_valid, w_rd_valid;
    logic w_rsp_valid;
    logic [WS-1:0] w_rsp_a, w_rsp_b;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // bench reference model
    longint unsigned m_raw_a, m_raw_b;
    int m_act, m_last;

    always #(CLK_PERIOD/2) clk = ~clk;

    pmc_core_counter uut (
        .clk(clk), .rst_n(rst_n), .retire_i(retire),
        .cfg_valid_i(cfg_valid), .cfg_mode_i(cfg_mode), .cfg_clear_i(cfg_clear),
        .rd_valid_i(rd_valid), .rd_both_i(rd_both),
        .rsp_valid_o(rsp_valid), .rsp_a_o(rsp_a), .rsp_b_o(rsp_b)
    );

    pmc_core_counter #(.CNT_W(WS), .FRAC_W(4)) uut_w (
        .clk(clk), .rst_n(rst_n), .retire_i(1'b0),
        .cfg_valid_i(w_cfg_valid), .cfg_mode_i(3'd0), .cfg_clear_i(1'b1),
        .rd_valid_i(w_rd_valid), .rd_both_i(1'b0),
        .rsp_valid_o(w_rsp_valid), .rsp_a_o(w_rsp_a), .rsp_b_o(w_rsp_b)
    );

    function automatic logic [W-1:0] vis(input longint unsigned raw);
        logic [W-1:0] v;
        v = raw[W-1:0];
        v[3:0] = 4'd0;
        return v;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint unsigned act,
                       input longint unsigned exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic cv, input logic [2:0] cm, input logic cc,
                        input logic rv, input logic rb, input logic rt, input string tag);
        logic exp_v;
        logic [W-1:0] exp_a, exp_b;
        cfg_valid = cv; cfg_mode = cm; cfg_clear = cc;
        rd_valid  = rv; rd_both  = rb; retire   = rt;
        @(posedge clk);
        exp_v = cv | rv;
        exp_a = vis(m_raw_a);
        exp_b = cv ? vis(m_raw_b) : (rb ? vis(m_raw_b) : '0);
        if (cv && cc) begin
            m_raw_a = 0; m_raw_b = 0;
        end else begin
            case (m_act)
                0: m_raw_a += 1;
                1: m_raw_a += rt;
                3: begin m_raw_a += 1; m_raw_b += rt; end
                default: ;
            endcase
        end
        if (cv) begin
            if (cm == 0 || cm == 1 || cm == 3 || cm == 4) begin
                m_act = cm; m_last = cm;
            end else begin
                m_act = m_last;
            end
        end
        @(negedge clk);
        chk(rsp_valid == exp_v, {tag, " valid"}, rsp_valid, exp_v);
        if (exp_v) begin
            chk(rsp_a == exp_a, {tag, " data A"}, rsp_a, exp_a);
            chk(rsp_b == exp_b, {tag, " data B"}, rsp_b, exp_b);
            chk(rsp_a[3:0] == 0, "R5 low bits", rsp_a[3:0], 0);
        end
        cfg_valid = 0; rd_valid = 0; retire = 0;
    endtask

    task automatic idle(input int n, input bit rt_pat, input string tag);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, rt_pat && (i % 3 != 0), tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1f2e3d));
        rst_n = 0; retire = 0; cfg_valid = 0; cfg_mode = 0; cfg_clear = 0;
        rd_valid = 0; rd_both = 0; w_cfg_valid = 0; w_rd_valid = 0;
        m_raw_a = 0; m_raw_b = 0; m_act = 4; m_last = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(rsp_valid == 0, "R1 valid low after reset", rsp_valid, 0);

        // R6: wrap of the narrow instance: 300 counted cycles in an 8-bit counter
        w_cfg_valid = 1; @(negedge clk); w_cfg_valid = 0;
        repeat (300) @(negedge clk);
        w_rd_valid = 1; @(negedge clk); w_rd_valid = 0;
        chk(w_rsp_valid == 1, "R6 wrap response", w_rsp_valid, 1);
        chk(w_rsp_a == 8'h20, "R6 wrap value", w_rsp_a, 8'h20);

        // R1: main instance still disabled since reset, nothing counted
        idle(5, 1, "R1");
        step(0, 0, 0, 1, 1, 0, "R1 read both");
        chk(rsp_a == 0 && rsp_b == 0, "R1 counters zero", rsp_a, 0);

        // R7: reuse with no prior selection counts cycles
        step(1, 3'd2, 0, 0, 0, 0, "R7 reuse cfg");
        idle(40, 0, "R7");
        step(0, 0, 0, 1, 0, 0, "R7 read");
        chk(rsp_a == 36'd32, "R7 default cycles", rsp_a, 32);

        // R3 / R10: switch to instructions keeping the count
        step(1, 3'd1, 0, 0, 0, 1, "R10 keep cfg");
        idle(37, 1, "R3");
        step(0, 0, 0, 1, 1, 0, "R3 read both");
        chk(rsp_b == 0, "R3 B holds", rsp_b, 0);

        // R9 / R4: clear and count both
        step(1, 3'd3, 1, 0, 0, 1, "R9 clear cfg");
        step(0, 0, 0, 1, 1, 0, "R9 read after clear");
        idle(70, 1, "R4");
        step(0, 0, 0, 1, 1, 1, "R4 read both");
        step(0, 0, 0, 1, 0, 0, "R11 single read");
        chk(rsp_b == 0, "R11 B zero", rsp_b, 0);

        // R8: disable freezes
        step(1, 3'd4, 0, 0, 0, 1, "R8 off cfg");
        idle(50, 1, "R8");
        step(0, 0, 0, 1, 1, 1, "R8 read both");

        // R7: unused code after disable stays disabled, reuse after both
        step(1, 3'd6, 0, 0, 0, 0, "R7 code6");
        idle(20, 1, "R7");
        step(1, 3'd3, 0, 0, 0, 0, "R7 both");
        step(1, 3'd5, 0, 0, 0, 1, "R7 code5");
        idle(33, 1, "R7");
        step(0, 0, 0, 1, 1, 0, "R7 read");

        // R2: clearing cycle-mode write, then immediate reads
        step(1, 3'd0, 1, 0, 0, 1, "R2 cfg");
        step(0, 0, 0, 1, 1, 0, "R2 first read");
        chk(rsp_a == 0, "R2 value at switch", rsp_a, 0);
        idle(16, 0, "R2");
        step(0, 0, 0, 1, 1, 0, "R2 after 17");

        // R12: config and read together
        step(1, 3'd1, 0, 1, 0, 1, "R12 collide");

        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic cv, cc, rv, rb, rt;
            logic [2:0] cm;
            cv = ($urandom % 16) == 0;
            cm = 3'($urandom % 8);
            cc = ($urandom % 3) == 0;
            rv = ($urandom % 4) == 0;
            rb = $urandom % 2;
            rt = $urandom % 2;
            step(cv, cm, cc, rv, rb, rt, cv ? (rv ? "R12" : "R10") : "R11");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule